// File: doc/BRIEF.md
# Synthesizer Control Word Receiver (I2C write slave)

This block is the serial front end of a frequency synthesizer. It listens to an I2C bus as a write-only slave, oversampling SCL and SDA with the system clock. It recognises start and stop conditions and answers one of four device addresses, which a 2-bit strap input selects. Accepted bytes are acknowledged by pulling SDA low.

After the address, data bytes arrive in pairs. The top bit of the first byte of each pair decides what the pair means. A clear bit makes the pair a 15-bit division ratio. A set bit makes it a control byte followed by a band byte. A pair reaches the output latches only when both of its bytes have arrived. A lone trailing byte is dropped. Bytes beyond the fourth are neither used nor acknowledged.

The latched control bits are decoded into three things: a reference-divider ratio, a mode for the three-state phase-comparator output and routing selects for two test outputs. Every start condition raises a one-cycle strobe. Downstream divider logic uses this strobe to pick up a new ratio. A ratio update is also marked by its own one-cycle load strobe.

Top module: `synth_ctl_i2c_rx`

## Requirements
- R1: The address byte is acknowledged only when it equals {4'b1100, addr_sel, 2'b00}, i.e. 0xC0, 0xC4, 0xC8 or 0xCC for addr_sel 0..3; bit 0 (write) must be 0.
- R2: After an accepted address, data bytes 1 to 4 are acknowledged (sda_pull high during the ninth SCL pulse); the fifth and later bytes are not acknowledged and change no output.
- R3: A pair whose first byte has bit 7 = 0 sets ratio = {first[6:0], second[7:0]} and pulses ratio_load high for exactly one clock; ratio changes at no other time.
- R4: A pair whose first byte has bit 7 = 1 latches the control bits first[6:0] = {R6,T,P,R3,R2,R1,R0} and band = {second[7], second[5], second[3], second[1]} (band[3] drives the B7 buffer, band[0] the B1 buffer; 1 = buffer on).
- R5: Output latches change only after the second and fourth data bytes; a single data byte, or a third byte with no fourth, leaves every output unchanged.
- R6: ref_div = 2048, 1024, 512, 256 for {R1,R0} = 00, 01, 10, 11.
- R7: pump_mode (0 normal, 1 high-Z, 2 forced high, 3 forced low) follows {R2,R6,T}: 000→0, 001→1, 010→2, 011→3, 100→0, 101→1, 110→0, 111→1.
- R8: b5_route is 1 (62.5 kHz tap) for {R2,R3}=10 and 2 (reference) for 11, but only while band[2] = 1, else 0; b7_route is 1 (halved divider output) only for {R2,R3}=11 with band[3] = 1.
- R9: start_stb is high for exactly one clock per start condition, including those to other addresses.
- R10: After an address that does not match (or has bit 0 set), no byte is acknowledged and no output latch changes until the next start.
- R11: After reset ratio = 0, band = 0, all control bits are 0 (ref_div 2048, pump_mode 0, routes 0, presc_bypass 0) and sda_pull = 0.
- R12: presc_bypass equals the latched P bit (control byte bit 4).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| addr_sel | input | 2 | Strap selecting which of four addresses answers |
| sda_pull | output | 1 | 1 = drive SDA low (acknowledge) |
| start_stb | output | 1 | One-cycle strobe per start condition |
| ratio | output | 15 | Latched divider ratio |
| ratio_load | output | 1 | One-cycle strobe when ratio is updated |
| band | output | 4 | Band buffer enables {B7,B5,B3,B1} |
| presc_bypass | output | 1 | 1 = prescaler bypassed |
| ref_div | output | 12 | Decoded reference division ratio |
| pump_mode | output | 2 | Comparator output mode: 0 normal, 1 high-Z, 2 high, 3 low |
| b5_route | output | 2 | B5 source: 0 band level, 1 62.5 kHz tap, 2 reference |
| b7_route | output | 1 | 1 = B7 carries the halved divider output |

## Verification
The hardest state to reach is the tail of a long transfer. Once four data bytes have been taken, the fifth must go unacknowledged, yet the earlier commits must hold. The discard of a half pair needs the same care. The bench drives six-byte and three-byte transfers bit by bit, and reads the acknowledge of every byte from the resolved SDA line during the ninth clock. The address path is covered the same way. All four strap values are tried, along with a mismatching address and an address with the read bit set, each carrying data that would visibly change the outputs.

// File: rtl/synth_ctl_pkg.sv
// Package: shared types for the synthesizer control receiver.
// Assumes the bus carries write transfers only.
package synth_ctl_pkg;

    // Phase-comparator output drive mode
    typedef enum logic [1:0] {
        PUMP_NORMAL = 2'd0,
        PUMP_HIZ    = 2'd1,
        PUMP_HIGH   = 2'd2,
        PUMP_LOW    = 2'd3
    } pump_mode_e;

    // Source selected for the B5 buffer
    typedef enum logic [1:0] {
        B5_BAND = 2'd0,
        B5_TAP  = 2'd1,
        B5_REF  = 2'd2
    } b5_route_e;

    // Receiver protocol state
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_ADDR = 2'd1,
        RX_DATA = 2'd2,
        RX_SKIP = 2'd3
    } rx_state_e;

    // Control byte fields, bit order as received in bits 6..0
    typedef struct packed {
        logic       r6;
        logic       t;
        logic       p;
        logic       r3;
        logic       r2;
        logic [1:0] rsel;
    } ctl_bits_t;

    localparam logic [3:0] ADDR_PREFIX = 4'b1100;

endpackage

// File: rtl/i2c_line_sampler.sv
// Module: i2c_line_sampler
// Synchronises SCL and SDA into the clock domain and flags start, stop
// and SCL edges. Assumes bus levels are held for several clocks.
module i2c_line_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int SCL_I = 0;
    localparam int SDA_I = 1;

    logic [1:0] raw;
    logic [1:0] now;
    logic [1:0] was;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < 2; g++) begin : g_line
        logic [STAGES-1:0] sh;
        logic              prev;
        // synchroniser chain plus one delayed copy for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh   <= '1;
                prev <= 1'b1;
            end else begin
                sh   <= {sh[STAGES-2:0], raw[g]};
                prev <= sh[STAGES-1];
            end
        end
        assign now[g] = sh[STAGES-1];
        assign was[g] = prev;
    end

    assign sda_lvl   = now[SDA_I];
    assign scl_rise  = now[SCL_I] & ~was[SCL_I];
    assign scl_fall  = ~now[SCL_I] & was[SCL_I];
    assign start_det = now[SCL_I] & was[SCL_I] & was[SDA_I] & ~now[SDA_I];
    assign stop_det  = now[SCL_I] & was[SCL_I] & ~was[SDA_I] & now[SDA_I];

endmodule

// File: rtl/i2c_write_rx.sv
// Module: i2c_write_rx
// Byte-level write receiver: shifts bits, matches the address and drives
// the acknowledge. Hands up to MAX_DATA data bytes upward, tagging whether
// each is the second of a pair. Assumes synchronised edge pulses as input.
module i2c_write_rx
    import synth_ctl_pkg::*;
#(
    parameter int MAX_DATA = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_det,
    input  logic       stop_det,
    input  logic [7:0] dev_addr,
    output logic       ack_pull,
    output logic       byte_stb,
    output logic [7:0] byte_data,
    output logic       byte_second
);
    localparam int CNT_W = $clog2(MAX_DATA + 1);
    localparam logic [3:0] LAST_BIT = 4'd8;
    localparam logic [3:0] ACK_BIT  = 4'd9;

    rx_state_e        state;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [CNT_W-1:0] dcnt;
    logic             in_byte;

    assign in_byte = (state == RX_ADDR) || (state == RX_DATA);

    // protocol sequencing, bit shifting and acknowledge control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            bit_cnt     <= '0;
            shreg       <= '0;
            dcnt        <= '0;
            ack_pull    <= 1'b0;
            byte_stb    <= 1'b0;
            byte_data   <= '0;
            byte_second <= 1'b0;
        end else begin
            byte_stb <= 1'b0;
            if (start_det) begin
                state    <= RX_ADDR;
                bit_cnt  <= '0;
                dcnt     <= '0;
                ack_pull <= 1'b0;
            end else if (stop_det) begin
                state    <= RX_IDLE;
                ack_pull <= 1'b0;
            end else if (in_byte) begin
                if (scl_rise && bit_cnt < LAST_BIT) begin
                    shreg   <= {shreg[6:0], sda_lvl};
                    bit_cnt <= bit_cnt + 4'd1;
                end else if (scl_fall && bit_cnt == LAST_BIT) begin
                    bit_cnt <= ACK_BIT;
                    if (state == RX_ADDR) begin
                        ack_pull <= (shreg == dev_addr);
                        if (shreg != dev_addr) begin
                            state <= RX_SKIP;
                        end
                    end else if (dcnt < CNT_W'(MAX_DATA)) begin
                        ack_pull    <= 1'b1;
                        byte_stb    <= 1'b1;
                        byte_data   <= shreg;
                        byte_second <= dcnt[0];
                        dcnt        <= dcnt + 1'b1;
                    end else begin
                        ack_pull <= 1'b0;
                    end
                end else if (scl_fall && bit_cnt == ACK_BIT) begin
                    ack_pull <= 1'b0;
                    bit_cnt  <= '0;
                    if (state == RX_ADDR) begin
                        state <= RX_DATA;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/pair_assembler.sv
// Module: pair_assembler
// Pairs data bytes and commits a complete pair either to the ratio latch
// or to the control/band latches, chosen by bit 7 of the first byte.
// Assumes byte_second marks the closing byte of a pair.
module pair_assembler
    import synth_ctl_pkg::*;
#(
    parameter int RATIO_W = 15,
    parameter int BANDS   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_stb,
    input  logic [7:0]         byte_data,
    input  logic               byte_second,
    output logic [RATIO_W-1:0] ratio,
    output logic               ratio_load,
    output ctl_bits_t          ctl,
    output logic [BANDS-1:0]   band
);
    localparam int HI_W = RATIO_W - 8;

    logic [7:0] hold;

    // hold the opening byte, then commit the pair on its closing byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold       <= '0;
            ratio      <= '0;
            ratio_load <= 1'b0;
            ctl        <= '0;
            band       <= '0;
        end else begin
            ratio_load <= 1'b0;
            if (byte_stb) begin
                if (!byte_second) begin
                    hold <= byte_data;
                end else if (!hold[7]) begin
                    ratio      <= {hold[HI_W-1:0], byte_data};
                    ratio_load <= 1'b1;
                end else begin
                    ctl <= ctl_bits_t'(hold[6:0]);
                    for (int k = 0; k < BANDS; k++) begin
                        band[k] <= byte_data[2*k+1];
                    end
                end
            end
        end
    end

endmodule

// File: rtl/ctl_decoder.sv
// Module: ctl_decoder
// Combinational decode of latched control bits into reference ratio,
// comparator drive mode and test-output routing. Assumes stable inputs.
module ctl_decoder
    import synth_ctl_pkg::*;
#(
    parameter int REF_LOG2 = 11
) (
    input  logic              r6,
    input  logic              t,
    input  logic              r3,
    input  logic              r2,
    input  logic [1:0]        rsel,
    input  logic              b5_on,
    input  logic              b7_on,
    output logic [REF_LOG2:0] ref_div,
    output pump_mode_e        pump,
    output b5_route_e         b5_src,
    output logic              b7_src
);
    localparam int REF_W = REF_LOG2 + 1;
    localparam logic [REF_W-1:0] REF_TOP = REF_W'(1) << REF_LOG2;

    // reference ratio halves per step of the select
    always_comb begin
        ref_div = REF_TOP >> rsel;
    end

    // comparator drive: forcing only when R2 is clear and R6 set
    always_comb begin
        if (!r2 && r6) begin
            pump = t ? PUMP_LOW : PUMP_HIGH;
        end else begin
            pump = t ? PUMP_HIZ : PUMP_NORMAL;
        end
    end

    // test routes, each gated by its own buffer enable
    always_comb begin
        b5_src = B5_BAND;
        if (r2 && b5_on) begin
            b5_src = r3 ? B5_REF : B5_TAP;
        end
        b7_src = r2 && r3 && b7_on;
    end

endmodule

// File: rtl/synth_ctl_i2c_rx.sv
// Module: synth_ctl_i2c_rx
// Top of the synthesizer control receiver: bus sampling, byte reception,
// pair assembly and control decode. Assumes a write-only bus and a system
// clock at least ten times faster than SCL.
module synth_ctl_i2c_rx
    import synth_ctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int MAX_DATA    = 4,
    parameter int RATIO_W     = 15,
    parameter int REF_LOG2    = 11
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    input  logic [1:0]         addr_sel,
    output logic               sda_pull,
    output logic               start_stb,
    output logic [RATIO_W-1:0] ratio,
    output logic               ratio_load,
    output logic [3:0]         band,
    output logic               presc_bypass,
    output logic [REF_LOG2:0]  ref_div,
    output logic [1:0]         pump_mode,
    output logic [1:0]         b5_route,
    output logic               b7_route
);
    localparam int BANDS = 4;
    localparam int B5_I  = 2;
    localparam int B7_I  = 3;

    logic       sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic       byte_stb, byte_second;
    logic [7:0] byte_data;
    logic [7:0] dev_addr;
    ctl_bits_t  ctl;
    pump_mode_e pump;
    b5_route_e  b5_src;

    assign dev_addr = {ADDR_PREFIX, addr_sel, 2'b00};

    i2c_line_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_write_rx #(.MAX_DATA(MAX_DATA)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .sda_lvl     (sda_lvl),
        .scl_rise    (scl_rise),
        .scl_fall    (scl_fall),
        .start_det   (start_det),
        .stop_det    (stop_det),
        .dev_addr    (dev_addr),
        .ack_pull    (sda_pull),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .byte_second (byte_second)
    );

    pair_assembler #(.RATIO_W(RATIO_W), .BANDS(BANDS)) u_pairs (
        .clk         (clk),
        .rst_n       (rst_n),
        .byte_stb    (byte_stb),
        .byte_data   (byte_data),
        .byte_second (byte_second),
        .ratio       (ratio),
        .ratio_load  (ratio_load),
        .ctl         (ctl),
        .band        (band)
    );

    ctl_decoder #(.REF_LOG2(REF_LOG2)) u_dec (
        .r6      (ctl.r6),
        .t       (ctl.t),
        .r3      (ctl.r3),
        .r2      (ctl.r2),
        .rsel    (ctl.rsel),
        .b5_on   (band[B5_I]),
        .b7_on   (band[B7_I]),
        .ref_div (ref_div),
        .pump    (pump),
        .b5_src  (b5_src),
        .b7_src  (b7_route)
    );

    assign start_stb    = start_det;
    assign presc_bypass = ctl.p;
    assign pump_mode    = pump;
    assign b5_route     = b5_src;

endmodule

// File: rtl/synth_ctl_i2c_rx_checker.sv
// Module: synth_ctl_i2c_rx_checker
// Temporal checks on the receiver's ports, attached by bind.
module synth_ctl_i2c_rx_checker #(
    parameter int RATIO_W  = 15,
    parameter int REF_LOG2 = 11
) (
    input logic               clk,
    input logic               rst_n,
    input logic               sda_pull,
    input logic               start_stb,
    input logic [RATIO_W-1:0] ratio,
    input logic               ratio_load,
    input logic [3:0]         band,
    input logic [REF_LOG2:0]  ref_div,
    input logic [1:0]         b5_route,
    input logic               b7_route
);

    a_r9_start_single : assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !start_stb);

    a_r2_ack_cleared_by_start : assert property (@(posedge clk) disable iff (!rst_n)
        start_stb |=> !sda_pull);

    a_r3_load_single : assert property (@(posedge clk) disable iff (!rst_n)
        ratio_load |=> !ratio_load);

    a_r3_ratio_only_on_load : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ratio) |-> ratio_load);

    a_r4_band_not_with_ratio : assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(band) |-> !ratio_load);

    a_r6_ref_div_power_of_two : assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ref_div) == 1);

    a_r8_b5_route_gated : assert property (@(posedge clk) disable iff (!rst_n)
        (b5_route != 2'd0) |-> band[2]);

    a_r8_b7_route_gated : assert property (@(posedge clk) disable iff (!rst_n)
        b7_route |-> band[3]);

endmodule

bind synth_ctl_i2c_rx synth_ctl_i2c_rx_checker #(
    .RATIO_W  (RATIO_W),
    .REF_LOG2 (REF_LOG2)
) u_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_pull   (sda_pull),
    .start_stb  (start_stb),
    .ratio      (ratio),
    .ratio_load (ratio_load),
    .band       (band),
    .ref_div    (ref_div),
    .b5_route   (b5_route),
    .b7_route   (b7_route)
);

// File: tb/tb_synth_ctl_i2c_rx.sv
// Bench: drives bit-level write transfers, keeps a behavioural model of the
// latched state and compares it against the outputs on every clock.
module tb_synth_ctl_i2c_rx;

    typedef logic [7:0] bq_t[$];

    localparam int Q = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [1:0]  addr_sel = 2'd0;
    logic        sda_line;
    logic        sda_pull, start_stb, ratio_load, presc_bypass, b7_route;
    logic [14:0] ratio;
    logic [3:0]  band;
    logic [11:0] ref_div;
    logic [1:0]  pump_mode, b5_route;

    assign sda_line = sda_m & ~sda_pull;

    synth_ctl_i2c_rx dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .addr_sel     (addr_sel),
        .sda_pull     (sda_pull),
        .start_stb    (start_stb),
        .ratio        (ratio),
        .ratio_load   (ratio_load),
        .band         (band),
        .presc_bypass (presc_bypass),
        .ref_div      (ref_div),
        .pump_mode    (pump_mode),
        .b5_route     (b5_route),
        .b7_route     (b7_route)
    );

    int checks = 0;
    int failures = 0;
    bit settled = 1'b0;
    bit finished = 1'b0;

    // model state
    logic [14:0] exp_ratio = '0;
    logic [6:0]  exp_ctl = '0;
    logic [3:0]  exp_band = '0;
    int          exp_loads = 0;
    int          exp_starts = 0;
    int          act_loads = 0;
    int          act_starts = 0;

    function automatic logic [11:0] m_ref(logic [6:0] c);
        case (c[1:0])
            2'b00:   return 12'd2048;
            2'b01:   return 12'd1024;
            2'b10:   return 12'd512;
            default: return 12'd256;
        endcase
    endfunction

    function automatic logic [1:0] m_pump(logic [6:0] c);
        case ({c[2], c[6], c[5]})
            3'b000: return 2'd0;
            3'b001: return 2'd1;
            3'b010: return 2'd2;
            3'b011: return 2'd3;
            3'b100: return 2'd0;
            3'b101: return 2'd1;
            3'b110: return 2'd0;
            default: return 2'd1;
        endcase
    endfunction

    function automatic logic [1:0] m_b5(logic [6:0] c, logic [3:0] b);
        if (!b[2]) return 2'd0;
        case ({c[2], c[3]})
            2'b10:   return 2'd1;
            2'b11:   return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic m_b7(logic [6:0] c, logic [3:0] b);
        return b[3] && c[2] && c[3];
    endfunction

    function automatic logic [7:0] mk_ctl(logic r6, logic t, logic p, logic r3,
                                          logic r2, logic [1:0] rs);
        return {1'b1, r6, t, p, r3, r2, rs};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // count strobes seen at the clock edge
    always @(posedge clk) begin
        if (rst_n && ratio_load) act_loads++;
        if (rst_n && start_stb) act_starts++;
    end

    // compare latched outputs to the model on every clock while idle
    always @(negedge clk) begin
        if (rst_n && settled && !finished) begin
            checks++;
            if (ratio !== exp_ratio || band !== exp_band ||
                presc_bypass !== exp_ctl[4] || ref_div !== m_ref(exp_ctl) ||
                pump_mode !== m_pump(exp_ctl) ||
                b5_route !== m_b5(exp_ctl, exp_band) ||
                b7_route !== m_b7(exp_ctl, exp_band)) begin
                failures++;
                $display("FAIL R3 R4 R6 R7 R8 R12 monitor actual=%h/%h/%h expected=%h/%h/%h",
                         ratio, band, {presc_bypass, ref_div, pump_mode, b5_route, b7_route},
                         exp_ratio, exp_band,
                         {exp_ctl[4], m_ref(exp_ctl), m_pump(exp_ctl),
                          m_b5(exp_ctl, exp_band), m_b7(exp_ctl, exp_band)});
            end
        end
    end

    task automatic wait_q();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_q();
        scl_m = 1'b1; wait_q();
        sda_m = 1'b1; wait_q();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b;    wait_q();
        scl_m = 1'b1; wait_q(); wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        for (int k = 7; k >= 0; k--) put_bit(b[k]);
        sda_m = 1'b1; wait_q();
        scl_m = 1'b1; wait_q();
        acked = (sda_line === 1'b0);
        wait_q();
        scl_m = 1'b0; wait_q();
    endtask

    // one full write transfer, with model update and end-of-transfer checks
    task automatic frame(input logic [7:0] ab, input bq_t d, input string tag);
        logic       match;
        logic       ackv;
        logic [7:0] hold;
        hold = '0;
        settled = 1'b0;
        bus_start();
        exp_starts++;
        send_byte(ab, ackv);
        match = (ab == {4'b1100, addr_sel, 2'b00});
        chk(match ? "R1" : "R10", {tag, " address ack"}, 32'(ackv), 32'(match));
        foreach (d[i]) begin
            send_byte(d[i], ackv);
            if (!match) chk("R10", {tag, " data ack"}, 32'(ackv), 32'd0);
            else chk("R2", {tag, " data ack"}, 32'(ackv), 32'(i < 4));
            if (match && i < 4) begin
                if (i % 2 == 0) hold = d[i];
                else if (!hold[7]) begin
                    exp_ratio = {hold[6:0], d[i]};
                    exp_loads++;
                end else begin
                    exp_ctl  = hold[6:0];
                    exp_band = {d[i][7], d[i][5], d[i][3], d[i][1]};
                end
            end
        end
        bus_stop();
        repeat (4) @(negedge clk);
        settled = 1'b1;
        chk("R3",  {tag, " ratio"},      32'(ratio), 32'(exp_ratio));
        chk("R3",  {tag, " load count"}, 32'(act_loads), 32'(exp_loads));
        chk("R4",  {tag, " band"},       32'(band), 32'(exp_band));
        chk("R6",  {tag, " ref_div"},    32'(ref_div), 32'(m_ref(exp_ctl)));
        chk("R7",  {tag, " pump_mode"},  32'(pump_mode), 32'(m_pump(exp_ctl)));
        chk("R8",  {tag, " b5_route"},   32'(b5_route), 32'(m_b5(exp_ctl, exp_band)));
        chk("R8",  {tag, " b7_route"},   32'(b7_route), 32'(m_b7(exp_ctl, exp_band)));
        chk("R12", {tag, " presc"},      32'(presc_bypass), 32'(exp_ctl[4]));
        chk("R9",  {tag, " start count"}, 32'(act_starts), 32'(exp_starts));
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11: reset state
        chk("R11", "ratio",    32'(ratio), 32'd0);
        chk("R11", "band",     32'(band), 32'd0);
        chk("R11", "sda_pull", 32'(sda_pull), 32'd0);
        chk("R11", "ref_div",  32'(ref_div), 32'd2048);
        chk("R11", "pump",     32'(pump_mode), 32'd0);
        chk("R11", "routes",   32'({b5_route, b7_route}), 32'd0);
        chk("R11", "presc",    32'(presc_bypass), 32'd0);
        settled = 1'b1;

        frame(8'hC0, '{8'h12, 8'h34}, "R3 freq pair");
        frame(8'hC0, '{mk_ctl(0, 0, 1, 0, 0, 2'b01), 8'hAA}, "R4 ctl pair");
        frame(8'hC0, '{8'h7F, 8'hFF, mk_ctl(0, 0, 0, 0, 0, 2'b10), 8'h02}, "R3 freq then ctl");
        frame(8'hC0, '{mk_ctl(1, 1, 1, 0, 0, 2'b11), 8'h80, 8'h01, 8'h00}, "R4 ctl then freq");
        frame(8'hC0, '{8'h05, 8'h06, mk_ctl(0, 0, 0, 0, 0, 2'b00)}, "R5 lone third");
        frame(8'hC0, '{8'h11}, "R5 single byte");
        frame(8'hC0, '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06}, "R2 six bytes");
        frame(8'hC4, '{8'h2A, 8'h2A}, "R10 other address");
        frame(8'hC1, '{8'h3C, 8'h3C}, "R10 read bit");
        for (int s = 1; s < 4; s++) begin
            addr_sel = 2'(s);
            frame({4'b1100, 2'(s), 2'b00}, '{8'(s), 8'h10}, "R1 strap");
        end
        addr_sel = 2'd0;
        for (int v = 0; v < 8; v++) begin
            frame(8'hC0, '{mk_ctl(v[1], v[0], 0, 0, v[2], 2'b00), 8'h00}, "R7 pump");
        end
        for (int r = 0; r < 4; r++) begin
            frame(8'hC0, '{mk_ctl(0, 0, r[0], 0, 0, 2'(r)), 8'h00}, "R6 ref");
        end
        for (int rr = 0; rr < 4; rr++) begin
            for (int bb = 0; bb < 4; bb++) begin
                frame(8'hC0, '{mk_ctl(0, 0, 0, rr[0], rr[1], 2'b00),
                               {bb[1], 1'b0, bb[0], 5'b00010}}, "R8 routes");
            end
        end

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog run did not complete actual=hung expected=done");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule